// File: doc/BRIEF.md
# Timed Asynchronous SRAM Controller

This block is a synchronous master for an external asynchronous static RAM that holds 262,144 words of 16 bits, with a separate select for each byte. A client hands it one word access at a time over a valid/ready handshake: a direction flag, an 18-bit word address, write data and a two-bit byte mask. The controller then plays out a fixed sequence of setup, strobe and recovery phases on the memory's control pins. Each phase lasts a parameterised number of system clock cycles.

The phase lengths are chosen from the memory's timing figures. The defaults suit a 100 MHz system clock. A read holds the address for 40 ns, keeps output enable low for 20 ns, and samples the data when output enable rises. A write keeps write enable low for 10 ns, with the address, byte selects and data set up 10 ns earlier. The controller owns the tri-state decision for the shared data bus. It turns the bus around so that it never drives while the memory's outputs may be on, and the memory never drives while the controller does. Read data comes back registered, with a one-cycle valid flag.

Top module: `asram_ctrl`

## Requirements
- R1: `req_ready` is high only while the controller is idle. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. A request presented while busy is ignored: its fields change nothing, and no write takes place.
- R2: A read accepted at edge E keeps `mem_oe_n` low for exactly RD_STROBE_CYC cycles, starting SETUP_CYC cycles after E. The word on `mem_dq_in` at the edge that ends the strobe appears on `rsp_rdata`.
- R3: After reset and whenever idle: `mem_ce_n`, `mem_oe_n`, `mem_we_n`, `mem_ub_n` and `mem_lb_n` are 1, `mem_dq_oe` and `rsp_valid` are 0, and `req_ready` is 1.
- R4: A write accepted at edge E keeps `mem_we_n` low for exactly WR_STROBE_CYC cycles, starting SETUP_CYC cycles after E, with `mem_oe_n` high for the whole transaction. `mem_dq_out` carries the request data for as long as `mem_dq_oe` is 1.
- R5: `mem_dq_oe` and a low `mem_oe_n` are never present in the same cycle, and `mem_dq_oe` is 0 in the cycle before any falling edge of `mem_oe_n`.
- R6: `mem_dq_oe` rises only in a cycle that follows a cycle with `mem_oe_n` high. During a write it stays 1 from the first setup cycle through the last recovery cycle.
- R7: While `mem_ce_n` is low, `mem_addr` is held at the accepted address. This covers setup, strobe and recovery.
- R8: On a write, mask bit 0 = 1 drives `mem_lb_n` low, enabling bits 7:0. Mask bit 1 = 1 drives `mem_ub_n` low, enabling bits 15:8. A lane whose mask bit is 0 keeps its stored byte; with mask 00, the word is left unchanged.
- R9: On a read, both byte selects are low for the whole transaction, and `mem_we_n` stays high.
- R10: Each transaction keeps `mem_ce_n` low and `req_ready` low for exactly SETUP_CYC + strobe + RECOVER_CYC cycles after the accepting edge. The next cycle is idle. Each phase parameter is at least 1.
- R11: `rsp_valid` is high for exactly one cycle per read: the first recovery cycle. It is never high for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request may be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte enables for writes (bit 0 = low byte) |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_rdata | output | 16 | Registered read data |
| mem_addr | output | 18 | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper byte select, active low |
| mem_lb_n | output | 1 | Lower byte select, active low |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | Controller drives the data bus |
| mem_dq_in | input | 16 | Data from the memory |

## Verification
The access sequence is tried in several ways:
- A full-word write followed by a read. This shows whether data reaches the memory and returns through the sampling edge.
- Writes with masks 01, 10 and 00 over a known word. These tell apart the two lane mappings, and the case where the selects must stay off.
- A write at the highest address, then a read issued in the idle cycle after it. This exercises the bus turnaround, and a write immediately followed by a read.
- A read of a word never written.

On every transaction the bench holds a garbage write request on the inputs while the controller is busy. This separates a controller that ignores busy-time requests from one that latches them.

Every accepted access is traced cycle by cycle against the phase lengths. A bench memory model returns zero whenever output enable is off. A sample taken at the wrong edge therefore shows up as wrong data.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_SETUP   = 2'd1,
        PH_STROBE  = 2'd2,
        PH_RECOVER = 2'd3
    } asram_phase_e;

    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/asram_phase_cnt.sv
module asram_phase_cnt #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_len,
    output logic             last
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_len - CNT_W'(1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/asram_lane_sel.sv
module asram_lane_sel #(
    parameter int LANES = 2
) (
    input  logic             is_write,
    input  logic [LANES-1:0] mask,
    output logic [LANES-1:0] sel_n
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // reads open every lane; writes open only masked-in lanes
        assign sel_n[g] = is_write ? ~mask[g] : 1'b0;
    end
endmodule

// File: rtl/asram_rd_capture.sv
module asram_rd_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    output logic              vld,
    output logic [DATA_W-1:0] data
);
    logic              vld_d, vld_q;
    logic [DATA_W-1:0] data_d, data_q;

    always_comb begin
        vld_d  = capture;
        data_d = capture ? din : data_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            data_q <= '0;
        end else begin
            vld_q  <= vld_d;
            data_q <= data_d;
        end
    end

    assign vld  = vld_q;
    assign data = data_q;
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W        = 18,
    parameter int DATA_W        = 16,
    parameter int SETUP_CYC     = 1,
    parameter int RD_STROBE_CYC = 2,
    parameter int WR_STROBE_CYC = 1,
    parameter int RECOVER_CYC   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_mask,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_ub_n,
    output logic              mem_lb_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int LANES  = DATA_W / 8;
    localparam int MAX_PH = max_of4(SETUP_CYC, RD_STROBE_CYC, WR_STROBE_CYC, RECOVER_CYC);
    localparam int CNT_W  = $clog2(MAX_PH + 1);
    localparam logic [CNT_W-1:0] LEN_SETUP = CNT_W'(SETUP_CYC);
    localparam logic [CNT_W-1:0] LEN_RD    = CNT_W'(RD_STROBE_CYC);
    localparam logic [CNT_W-1:0] LEN_WR    = CNT_W'(WR_STROBE_CYC);
    localparam logic [CNT_W-1:0] LEN_REC   = CNT_W'(RECOVER_CYC);

    typedef struct packed {
        asram_phase_e       phase;
        logic               wr;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  wdata;
        logic [LANES-1:0]   sel_n;
        logic               ce_n;
        logic               oe_n;
        logic               we_n;
        logic               dq_oe;
        logic               ready;
    } ctrl_t;

    ctrl_t             ctl_d, ctl_q;
    logic              cnt_load;
    logic [CNT_W-1:0]  cnt_len;
    logic              cnt_last;
    logic              cap_d;
    logic [LANES-1:0]  lane_sel_n;

    asram_phase_cnt #(.CNT_W(CNT_W)) i_phase_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_len (cnt_len),
        .last     (cnt_last)
    );

    asram_lane_sel #(.LANES(LANES)) i_lane_sel (
        .is_write (req_write),
        .mask     (req_mask[LANES-1:0]),
        .sel_n    (lane_sel_n)
    );

    asram_rd_capture #(.DATA_W(DATA_W)) i_rd_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (cap_d),
        .din     (mem_dq_in),
        .vld     (rsp_valid),
        .data    (rsp_rdata)
    );

    always_comb begin
        ctl_d    = ctl_q;
        cnt_load = 1'b0;
        cnt_len  = '0;
        cap_d    = 1'b0;

        // phase sequencing
        unique case (ctl_q.phase)
            PH_IDLE: begin
                if (req_valid && ctl_q.ready) begin
                    ctl_d.phase = PH_SETUP;
                    ctl_d.wr    = req_write;
                    ctl_d.addr  = req_addr;
                    ctl_d.wdata = req_wdata;
                    ctl_d.sel_n = lane_sel_n;
                    cnt_load    = 1'b1;
                    cnt_len     = LEN_SETUP;
                end
            end
            PH_SETUP: begin
                if (cnt_last) begin
                    ctl_d.phase = PH_STROBE;
                    cnt_load    = 1'b1;
                    cnt_len     = ctl_q.wr ? LEN_WR : LEN_RD;
                end
            end
            PH_STROBE: begin
                if (cnt_last) begin
                    ctl_d.phase = PH_RECOVER;
                    cnt_load    = 1'b1;
                    cnt_len     = LEN_REC;
                    cap_d       = !ctl_q.wr;
                end
            end
            PH_RECOVER: begin
                if (cnt_last) begin
                    ctl_d.phase = PH_IDLE;
                    ctl_d.sel_n = '1;
                end
            end
            default: begin
                ctl_d.phase = PH_IDLE;
                ctl_d.sel_n = '1;
            end
        endcase

        // pin levels follow the phase being entered
        unique case (ctl_d.phase)
            PH_SETUP: begin
                ctl_d.ce_n  = 1'b0;
                ctl_d.oe_n  = 1'b1;
                ctl_d.we_n  = 1'b1;
                ctl_d.dq_oe = ctl_d.wr;
            end
            PH_STROBE: begin
                ctl_d.ce_n  = 1'b0;
                ctl_d.oe_n  = ctl_d.wr;
                ctl_d.we_n  = !ctl_d.wr;
                ctl_d.dq_oe = ctl_d.wr;
            end
            PH_RECOVER: begin
                ctl_d.ce_n  = 1'b0;
                ctl_d.oe_n  = 1'b1;
                ctl_d.we_n  = 1'b1;
                ctl_d.dq_oe = ctl_d.wr;
            end
            default: begin
                ctl_d.ce_n  = 1'b1;
                ctl_d.oe_n  = 1'b1;
                ctl_d.we_n  = 1'b1;
                ctl_d.dq_oe = 1'b0;
            end
        endcase
        ctl_d.ready = (ctl_d.phase == PH_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.phase <= PH_IDLE;
            ctl_q.sel_n <= '1;
            ctl_q.ce_n  <= 1'b1;
            ctl_q.oe_n  <= 1'b1;
            ctl_q.we_n  <= 1'b1;
            ctl_q.dq_oe <= 1'b0;
            ctl_q.ready <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready  = ctl_q.ready;
    assign mem_addr   = ctl_q.addr;
    assign mem_ce_n   = ctl_q.ce_n;
    assign mem_oe_n   = ctl_q.oe_n;
    assign mem_we_n   = ctl_q.we_n;
    assign mem_lb_n   = ctl_q.sel_n[0];
    assign mem_ub_n   = ctl_q.sel_n[LANES-1];
    assign mem_dq_out = ctl_q.wdata;
    assign mem_dq_oe  = ctl_q.dq_oe;
endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_dq_oe
);
    // R3: idle means deselected
    a_r3_idle_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> mem_ce_n);

    // R1: busy while selected
    a_r1_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> !req_ready);

    // R5: no contention on the data bus
    a_r5_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_dq_oe && !mem_oe_n));

    // R5: bus released the cycle before output enable falls
    a_r5_release_first: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> !$past(mem_dq_oe));

    // R6: drive starts only after output enable was high
    a_r6_drive_after_oe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> $past(mem_oe_n));

    // R4: write strobe only with bus driven and outputs off
    a_r4_we_with_drive: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_oe_n && mem_dq_oe && !mem_ce_n));

    // R7: address steady while selected
    a_r7_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

    // R11: response valid lasts one cycle
    a_r11_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
endmodule

bind asram_ctrl asram_ctrl_chk #(.ADDR_W(ADDR_W)) i_asram_ctrl_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/test_asram_ctrl.sv
module test_asram_ctrl;
    localparam int S   = 2;
    localparam int RDT = 3;
    localparam int WRT = 2;
    localparam int REC = 2;
    localparam int WD_CYC = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [17:0] mem_addr;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n;
    logic [15:0] mem_dq_out;
    logic        mem_dq_oe;
    logic [15:0] mem_dq_in = '0;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [15:0] sram  [logic [17:0]];
    logic [15:0] score [logic [17:0]];

    always #10 clk = ~clk;

    asram_ctrl #(
        .SETUP_CYC(S), .RD_STROBE_CYC(RDT), .WR_STROBE_CYC(WRT), .RECOVER_CYC(REC)
    ) i_asram_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    function automatic logic [15:0] peek(input logic [15:0] arr [logic [17:0]], input logic [17:0] a);
        return arr.exists(a) ? arr[a] : 16'h0000;
    endfunction

    // SRAM model: writes lanes on posedge during strobe, drives reads after negedge
    always @(posedge clk) begin
        if (!mem_ce_n && !mem_we_n && mem_dq_oe) begin
            logic [15:0] w;
            w = peek(sram, mem_addr);
            if (!mem_lb_n) w[7:0]  = mem_dq_out[7:0];
            if (!mem_ub_n) w[15:8] = mem_dq_out[15:8];
            sram[mem_addr] = w;
        end
    end
    always @(negedge clk) begin
        mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n) ? peek(sram, mem_addr) : 16'h0000;
    end

    // bus turnaround monitor
    int   ovl_err = 0, rel_err = 0, drv_err = 0;
    logic prev_oe_n = 1'b1, prev_dq_oe = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_dq_oe && !mem_oe_n) ovl_err++;
            if (!mem_oe_n && prev_oe_n && prev_dq_oe) rel_err++;
            if (mem_dq_oe && !prev_dq_oe && !prev_oe_n) drv_err++;
        end
        prev_oe_n  = mem_oe_n;
        prev_dq_oe = mem_dq_oe;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    // one access; traces every cycle against the phase plan
    task automatic run_txn(input bit wr, input logic [17:0] a, input logic [15:0] wd,
                           input logic [1:0] m, output logic [15:0] rd);
        int strobe, tot;
        strobe = wr ? WRT : RDT;
        tot    = S + strobe + REC;
        rd     = 16'h0;
        @(negedge clk);
        check(req_ready == 1'b1, "R1 ready before request", int'(req_ready), 1);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd; req_mask = m;
        for (int k = 1; k <= tot + 1; k++) begin
            bit in_strobe;
            @(negedge clk);
            in_strobe = (k > S) && (k <= S + strobe);
            if (k == 1) begin
                // garbage write held while busy (R1 ignore)
                req_write = 1'b1; req_addr = a ^ 18'h2AAAA; req_wdata = 16'hDEAD; req_mask = 2'b11;
            end
            if (k == tot) req_valid = 1'b0;
            check(req_ready == (k > tot), "R10 ready vs busy", int'(req_ready), int'(k > tot));
            check(mem_ce_n == (k > tot), "R10 chip enable window", int'(mem_ce_n), int'(k > tot));
            if (k <= tot) check(mem_addr == a, "R7 address held", int'(mem_addr), int'(a));
            if (wr) begin
                check(mem_we_n == !in_strobe, "R4 write strobe", int'(mem_we_n), int'(!in_strobe));
                check(mem_oe_n == 1'b1, "R4 output enable off in write", int'(mem_oe_n), 1);
                check(mem_dq_oe == (k <= tot), "R6 drive window", int'(mem_dq_oe), int'(k <= tot));
                if (mem_dq_oe) check(mem_dq_out == wd, "R4 write data", int'(mem_dq_out), int'(wd));
                if (k <= tot) begin
                    check(mem_lb_n == !m[0], "R8 lower select", int'(mem_lb_n), int'(!m[0]));
                    check(mem_ub_n == !m[1], "R8 upper select", int'(mem_ub_n), int'(!m[1]));
                end
                check(rsp_valid == 1'b0, "R11 no response on write", int'(rsp_valid), 0);
            end else begin
                check(mem_oe_n == !in_strobe, "R2 output enable window", int'(mem_oe_n), int'(!in_strobe));
                check(mem_we_n == 1'b1, "R9 no write strobe on read", int'(mem_we_n), 1);
                check(mem_dq_oe == 1'b0, "R5 bus released on read", int'(mem_dq_oe), 0);
                if (k <= tot) check({mem_ub_n, mem_lb_n} == 2'b00, "R9 both lanes on read",
                                    int'({mem_ub_n, mem_lb_n}), 0);
                check(rsp_valid == (k == S + RDT + 1), "R11 response pulse", int'(rsp_valid),
                      int'(k == S + RDT + 1));
                if (rsp_valid) rd = rsp_rdata;
            end
        end
        if (wr) begin
            logic [15:0] w;
            w = peek(score, a);
            if (m[0]) w[7:0]  = wd[7:0];
            if (m[1]) w[15:8] = wd[15:8];
            score[a] = w;
        end
    endtask

    task automatic read_expect(input logic [17:0] a, input string tag);
        logic [15:0] rd;
        run_txn(1'b0, a, 16'h0, 2'b00, rd);
        check(rd == peek(score, a), tag, int'(rd), int'(peek(score, a)));
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(req_ready == 1'b1, "R3 reset ready", int'(req_ready), 1);
        check({mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n} == 5'b11111, "R3 reset pins",
              int'({mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n}), 5'h1F);
        check(mem_dq_oe == 1'b0, "R3 reset bus", int'(mem_dq_oe), 0);
        check(rsp_valid == 1'b0, "R3 reset response", int'(rsp_valid), 0);
    endtask

    task automatic t_full_word();
        logic [15:0] rd;
        run_txn(1'b1, 18'h00015, 16'hA5C3, 2'b11, rd);
        read_expect(18'h00015, "R2 full word read back");
    endtask

    task automatic t_lanes();
        logic [15:0] rd;
        run_txn(1'b1, 18'h00015, 16'h1177, 2'b01, rd);
        read_expect(18'h00015, "R8 lower lane only");
        run_txn(1'b1, 18'h00015, 16'h99EE, 2'b10, rd);
        read_expect(18'h00015, "R8 upper lane only");
        run_txn(1'b1, 18'h00015, 16'h0000, 2'b00, rd);
        read_expect(18'h00015, "R8 empty mask keeps word");
    endtask

    task automatic t_edge_addr_turnaround();
        logic [15:0] rd;
        run_txn(1'b1, 18'h3FFFF, 16'h5A0F, 2'b11, rd);
        read_expect(18'h3FFFF, "R2 top address after write");
        read_expect(18'h00100, "R2 unwritten word");
    endtask

    task automatic t_ignored();
        // garbage writes were offered at addr ^ 2AAAA while busy
        read_expect(18'h00015 ^ 18'h2AAAA, "R1 busy request ignored");
        read_expect(18'h3FFFF ^ 18'h2AAAA, "R1 busy request ignored high");
    endtask

    task automatic t_bus_monitor();
        check(ovl_err == 0, "R5 overlap count", ovl_err, 0);
        check(rel_err == 0, "R5 release before output enable", rel_err, 0);
        check(drv_err == 0, "R6 drive after output enable high", drv_err, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_full_word();
        t_lanes();
        t_edge_addr_turnaround();
        t_ignored();
        t_bus_monitor();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(WD_CYC * 20);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
            $finish;
        end
    end
endmodule